// File: doc/BRIEF.md
# Working Register File With Pair and Pointer Views

This block holds the general-purpose working registers of a small 8-bit CPU: 32 registers of 8 bits each. It has two combinational read ports, A and B. Each read port returns a single byte and the 16-bit pair that contains the addressed register. The single write port stores either one byte or a 16-bit register pair. Every register access completes in one clock cycle, and writes take effect at the next rising edge.

The six highest registers also act as three 16-bit address pointers. The block drives these pointers continuously on separate outputs. Load/store logic can also reach every register through a data-space byte port. Any data-space address from 0x0000 to 0x001F selects the register with that number. Any higher address falls outside the file, so a read returns zero and a write is discarded. If the instruction write port and the data-space write port name the same register in one cycle, the instruction write is stored.

Top module: `cpu_regfile`

## Requirements
- R1: A rising clock edge with `rst_n` low sets all 32 registers to zero. This reset is synchronous.
- R2: A byte write (`wr_en`=1, `wr_wide`=0) stores `wr_data[7:0]` into register `wr_idx` at the next rising edge. No other register changes.
- R3: A pair write (`wr_en`=1, `wr_wide`=1) stores `wr_data[7:0]` into register `wr_idx` with bit 0 cleared, and stores `wr_data[15:8]` into register `wr_idx` with bit 0 set. An odd `wr_idx` therefore writes the same pair as the even index below it.
- R4: Each read port returns its byte combinationally. Its word output is {register idx|1, register idx with bit 0 cleared}, with the high byte first.
- R5: `ptr_x` = {r27, r26}, `ptr_y` = {r29, r28} and `ptr_z` = {r31, r30}. Each pointer follows the current register contents.
- R6: When `ds_addr` is below 0x0020, `ds_hit` is 1 and `ds_rdata` shows register `ds_addr[4:0]`. A write with `ds_we`=1 then stores `ds_wdata` into that register.
- R7: When `ds_addr` is 0x0020 or higher, `ds_hit` is 0, `ds_rdata` is 0 and a data-space write changes no register.
- R8: If both write ports target the same register in one cycle, that register receives the instruction-port byte. This holds for the low and the high byte of a pair write.
- R9: A read of a register that is being written in the same cycle returns the old value until the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 5 | Register index for read port A |
| rd_a_byte | output | 8 | Register byte selected by `rd_a_idx` |
| rd_a_word | output | 16 | Register pair that contains `rd_a_idx` |
| rd_b_idx | input | 5 | Register index for read port B |
| rd_b_byte | output | 8 | Register byte selected by `rd_b_idx` |
| rd_b_word | output | 16 | Register pair that contains `rd_b_idx` |
| wr_en | input | 1 | Instruction write enable |
| wr_wide | input | 1 | 1 = pair write, 0 = byte write |
| wr_idx | input | 5 | Write register index (pair index when wide) |
| wr_data | input | 16 | Write data; only bits 7:0 are used for a byte write |
| ds_addr | input | 16 | Data-space address |
| ds_we | input | 1 | Data-space write enable |
| ds_wdata | input | 8 | Data-space write byte |
| ds_hit | output | 1 | High when `ds_addr` lies inside the register window |
| ds_rdata | output | 8 | Data-space read byte, or 0 when outside the window |
| ptr_x | output | 16 | Pointer view of registers 27:26 |
| ptr_y | output | 16 | Pointer view of registers 29:28 |
| ptr_z | output | 16 | Pointer view of registers 31:30 |

## Verification
An instruction write and a data-space write can land in the same cycle. They may target the same byte, the other byte of a pair, or two unrelated registers. The bench drives both write ports in one cycle: for the same register, for the high byte of a pair write, and for two different registers. It then reads back every register involved through the read ports. The instruction byte must appear wherever the two targets overlap, and the data-space byte must appear wherever they do not.

// File: rtl/regfile_pkg.sv
// Package regfile_pkg
// Holds the shared dimensions of the working register file.
// Assumes a file with a power-of-two number of byte-wide registers.
package regfile_pkg;
    localparam int NUM_REGS = 32;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int DS_ADDR_W = 16;
    localparam int NUM_PTRS = 3;
endpackage

// File: rtl/rf_write_arbiter.sv
// Module rf_write_arbiter
// Turns the instruction write port (byte or pair) and the data-space byte
// write into one enable and one data byte per register. Where the two ports
// overlap, the instruction port wins.
// Assumes ds_hit is already qualified by the address-window decode.
module rf_write_arbiter #(
    parameter int NREG = regfile_pkg::NUM_REGS,
    parameter int DW   = regfile_pkg::BYTE_W,
    parameter int IW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_wide,
    input  logic [IW-1:0]   wr_idx,
    input  logic [2*DW-1:0] wr_data,
    input  logic            ds_we,
    input  logic            ds_hit,
    input  logic [IW-1:0]   ds_idx,
    input  logic [DW-1:0]   ds_wdata,
    output logic            reg_we [NREG],
    output logic [DW-1:0]   reg_wd [NREG]
);
    logic [IW-1:0] pair_lo;
    logic [IW-1:0] pair_hi;
    logic [IW-1:0] lo_target;

    // Works out which index receives the low byte and which the high byte.
    always_comb begin
        pair_lo   = {wr_idx[IW-1:1], 1'b0};
        pair_hi   = {wr_idx[IW-1:1], 1'b1};
        lo_target = wr_wide ? pair_lo : wr_idx;
    end

    for (genvar k = 0; k < NREG; k++) begin : g_lane
        logic ins_lo, ins_hi, ds_sel;
        // Decodes each port for this register and applies the priority.
        always_comb begin
            ins_lo    = wr_en && (lo_target == IW'(k));
            ins_hi    = wr_en && wr_wide && (pair_hi == IW'(k));
            ds_sel    = ds_we && ds_hit && (ds_idx == IW'(k));
            reg_we[k] = ins_lo || ins_hi || ds_sel;
            if (ins_hi)      reg_wd[k] = wr_data[2*DW-1:DW];
            else if (ins_lo) reg_wd[k] = wr_data[DW-1:0];
            else             reg_wd[k] = ds_wdata;
        end
    end

    // A pair write always drives the odd register with the high data byte.
    assert_pair_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wide) |-> (reg_we[pair_hi] && reg_wd[pair_hi] == wr_data[2*DW-1:DW]));

    // A byte collision between the two ports keeps the instruction byte.
    assert_collision_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide && ds_we && ds_hit && ds_idx == wr_idx)
        |-> (reg_wd[wr_idx] == wr_data[DW-1:0]));
endmodule

// File: rtl/rf_storage.sv
// Module rf_storage
// Holds the register array. Each register loads its data byte when its
// enable is high and clears on a synchronous active-low reset.
// Assumes at most one data byte per register and cycle (arbitrated upstream).
module rf_storage #(
    parameter int NREG = regfile_pkg::NUM_REGS,
    parameter int DW   = regfile_pkg::BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we [NREG],
    input  logic [DW-1:0] reg_wd [NREG],
    output logic [DW-1:0] regs   [NREG]
);
    for (genvar k = 0; k < NREG; k++) begin : g_reg
        // Stores this register's byte, or clears it in reset.
        always_ff @(posedge clk) begin
            if (!rst_n)         regs[k] <= '0;
            else if (reg_we[k]) regs[k] <= reg_wd[k];
        end
    end

    logic chk_started;
    // Flags that one edge has passed, so $past has history.
    always_ff @(posedge clk) chk_started <= 1'b1;

    for (genvar k = 0; k < NREG; k++) begin : g_chk
        assert_reset_clear_R1: assert property (@(posedge clk)
            (chk_started && !$past(rst_n)) |-> (regs[k] == '0));
        assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(reg_we[k])) |-> (regs[k] == $past(reg_wd[k])));
        assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(reg_we[k])) |-> $stable(regs[k]));
    end
endmodule

// File: rtl/rf_read_mux.sv
// Module rf_read_mux
// One combinational read port. It returns the addressed byte and the
// pair that contains it, with the odd register as the high byte.
// Assumes NREG is even.
module rf_read_mux #(
    parameter int NREG = regfile_pkg::NUM_REGS,
    parameter int DW   = regfile_pkg::BYTE_W,
    parameter int IW   = $clog2(NREG)
) (
    input  logic [DW-1:0]   regs [NREG],
    input  logic [IW-1:0]   idx,
    output logic [DW-1:0]   rd_byte,
    output logic [2*DW-1:0] rd_word
);
    // Selects the byte and the even/odd pair for this index.
    always_comb begin
        rd_byte = regs[idx];
        rd_word = {regs[{idx[IW-1:1], 1'b1}], regs[{idx[IW-1:1], 1'b0}]};
    end
endmodule

// File: rtl/cpu_regfile.sv
// Module cpu_regfile
// Top of the working register file. It contains two read ports with byte
// and pair outputs, a byte/pair write port, the data-space byte window over
// the lowest addresses, and three pointer views of the top six registers.
// Assumes a single clock and a synchronous active-low reset.
module cpu_regfile #(
    parameter int NREG = regfile_pkg::NUM_REGS,
    parameter int DW   = regfile_pkg::BYTE_W,
    parameter int AW   = regfile_pkg::DS_ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] rd_a_idx,
    output logic [DW-1:0]           rd_a_byte,
    output logic [2*DW-1:0]         rd_a_word,
    input  logic [$clog2(NREG)-1:0] rd_b_idx,
    output logic [DW-1:0]           rd_b_byte,
    output logic [2*DW-1:0]         rd_b_word,
    input  logic                    wr_en,
    input  logic                    wr_wide,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [2*DW-1:0]         wr_data,
    input  logic [AW-1:0]           ds_addr,
    input  logic                    ds_we,
    input  logic [DW-1:0]           ds_wdata,
    output logic                    ds_hit,
    output logic [DW-1:0]           ds_rdata,
    output logic [2*DW-1:0]         ptr_x,
    output logic [2*DW-1:0]         ptr_y,
    output logic [2*DW-1:0]         ptr_z
);
    localparam int IW       = $clog2(NREG);
    localparam int NPTR     = regfile_pkg::NUM_PTRS;
    localparam int PTR_BASE = NREG - 2 * NPTR;

    logic [DW-1:0]   regs   [NREG];
    logic            reg_we [NREG];
    logic [DW-1:0]   reg_wd [NREG];
    logic [IW-1:0]   ds_idx;
    logic [2*DW-1:0] ptr_bus [NPTR];

    // Decodes the data-space window and reads the selected register.
    always_comb begin
        ds_idx   = ds_addr[IW-1:0];
        ds_hit   = (ds_addr[AW-1:IW] == '0);
        ds_rdata = ds_hit ? regs[ds_idx] : '0;
    end

    rf_write_arbiter #(.NREG(NREG), .DW(DW), .IW(IW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
        .ds_we(ds_we), .ds_hit(ds_hit), .ds_idx(ds_idx), .ds_wdata(ds_wdata),
        .reg_we(reg_we), .reg_wd(reg_wd)
    );

    rf_storage #(.NREG(NREG), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wd(reg_wd), .regs(regs)
    );

    rf_read_mux #(.NREG(NREG), .DW(DW), .IW(IW)) u_rd_a (
        .regs(regs), .idx(rd_a_idx), .rd_byte(rd_a_byte), .rd_word(rd_a_word)
    );

    rf_read_mux #(.NREG(NREG), .DW(DW), .IW(IW)) u_rd_b (
        .regs(regs), .idx(rd_b_idx), .rd_byte(rd_b_byte), .rd_word(rd_b_word)
    );

    for (genvar p = 0; p < NPTR; p++) begin : g_ptr
        // Builds pointer p from its even (low) and odd (high) registers.
        always_comb ptr_bus[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
    end

    // Maps the pointer views onto the named outputs.
    always_comb begin
        ptr_x = ptr_bus[0];
        ptr_y = ptr_bus[1];
        ptr_z = ptr_bus[2];
    end

    // Port A's pair view and the data-space read agree on the high byte.
    assert_pair_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_hit && ds_idx == {rd_a_idx[IW-1:1], 1'b1}) |-> (rd_a_word[2*DW-1:DW] == ds_rdata));

    // Reading the first pointer pair on port A gives the X pointer.
    assert_ptr_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == IW'(PTR_BASE)) |-> (rd_a_word == ptr_x));

    // The data-space read matches port B when both select the same register.
    assert_ds_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_hit && ds_idx == rd_b_idx) |-> (ds_rdata == rd_b_byte));

    // Outside the window, the data-space read returns zero.
    assert_ds_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_addr >= AW'(NREG)) |-> (!ds_hit && ds_rdata == '0));
endmodule

// File: tb/cpu_regfile_tb.sv
module cpu_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [7:0]  rd_a_byte, rd_b_byte, ds_wdata, ds_rdata;
    logic [15:0] rd_a_word, rd_b_word, wr_data, ds_addr, ptr_x, ptr_y, ptr_z;
    logic        wr_en, wr_wide, ds_we, ds_hit;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cpu_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_byte(rd_a_byte), .rd_a_word(rd_a_word),
        .rd_b_idx(rd_b_idx), .rd_b_byte(rd_b_byte), .rd_b_word(rd_b_word),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
        .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata),
        .ds_hit(ds_hit), .ds_rdata(ds_rdata),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z)
    );

    typedef struct packed {
        logic        wen;
        logic        wide;
        logic [4:0]  widx;
        logic [15:0] wdat;
        logic        dwe;
        logic [15:0] daddr;
        logic [7:0]  ddat;
        logic [4:0]  cidx;
        logic [7:0]  cexp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,1'b0,5'd5, 16'h00A5,1'b0,16'h0000,8'h00,5'd5, 8'hA5,4'd2}, // R2 byte write
        '{1'b1,1'b0,5'd6, 16'h003C,1'b0,16'h0000,8'h00,5'd5, 8'hA5,4'd2}, // R2 neighbour untouched
        '{1'b1,1'b1,5'd10,16'hBEEF,1'b0,16'h0000,8'h00,5'd10,8'hEF,4'd3}, // R3 low byte
        '{1'b0,1'b0,5'd0, 16'h0000,1'b0,16'h0000,8'h00,5'd11,8'hBE,4'd3}, // R3 high byte
        '{1'b1,1'b1,5'd13,16'h1234,1'b0,16'h0000,8'h00,5'd12,8'h34,4'd3}, // R3 odd index
        '{1'b1,1'b0,5'd8, 16'h0011,1'b1,16'h0008,8'h22,5'd8, 8'h11,4'd8}, // R8 same byte
        '{1'b1,1'b1,5'd20,16'hAAAA,1'b1,16'h0015,8'h55,5'd21,8'hAA,4'd8}, // R8 pair high byte
        '{1'b1,1'b0,5'd9, 16'h0044,1'b1,16'h001F,8'h55,5'd31,8'h55,4'd6}, // R6 disjoint targets
        '{1'b0,1'b0,5'd0, 16'h0000,1'b0,16'h0000,8'h00,5'd9, 8'h44,4'd8}, // R8 disjoint instr byte
        '{1'b0,1'b0,5'd0, 16'h0000,1'b1,16'h0007,8'h77,5'd7, 8'h77,4'd6}, // R6 window write
        '{1'b0,1'b0,5'd0, 16'h0000,1'b1,16'h0027,8'h99,5'd7, 8'h77,4'd7}  // R7 outside ignored
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_wide = 1'b0; wr_idx = '0; wr_data = '0;
        ds_we = 1'b0; ds_addr = 16'h0100; ds_wdata = '0;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rd_a_idx = '0; rd_b_idx = '0; idle();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state through pointers and reads
        check("R1", ptr_x | ptr_y | ptr_z, 16'h0000);
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i); #0.1;
            check("R1", {8'h00, rd_a_byte}, 16'h0000);
        end

        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            wr_en = VECS[v].wen; wr_wide = VECS[v].wide; wr_idx = VECS[v].widx;
            wr_data = VECS[v].wdat; ds_we = VECS[v].dwe; ds_addr = VECS[v].daddr;
            ds_wdata = VECS[v].ddat;
            @(posedge clk);
            @(negedge clk) idle();
            rd_b_idx = VECS[v].cidx; #1;
            check($sformatf("R%0d vec%0d", VECS[v].req, v), {8'h00, rd_b_byte}, {8'h00, VECS[v].cexp});
        end

        // R4: pair read on both ports, from either index of the pair
        rd_a_idx = 5'd11; rd_b_idx = 5'd10; #1;
        check("R4", rd_a_word, 16'hBEEF);
        check("R4", rd_b_word, 16'hBEEF);

        // R6: data-space read inside the window
        ds_addr = 16'h000A; #1;
        check("R6", {15'd0, ds_hit}, 16'd1);
        check("R6", {8'h00, ds_rdata}, 16'h00EF);
        // R7: data-space read outside the window
        ds_addr = 16'h0100; #1;
        check("R7", {15'd0, ds_hit}, 16'd0);
        check("R7", {8'h00, ds_rdata}, 16'h0000);
        ds_addr = 16'h0020; #1;
        check("R7", {15'd0, ds_hit}, 16'd0);

        // R5: pointer views loaded by pair and by data-space writes
        @(negedge clk) begin wr_en = 1'b1; wr_wide = 1'b1; wr_idx = 5'd26; wr_data = 16'hCAFE; ds_we = 1'b1; ds_addr = 16'h001C; ds_wdata = 8'h34; end
        @(posedge clk);
        @(negedge clk) begin wr_en = 1'b1; wr_wide = 1'b1; wr_idx = 5'd31; wr_data = 16'h8001; ds_we = 1'b1; ds_addr = 16'h001D; ds_wdata = 8'h12; end
        @(posedge clk);
        @(negedge clk) idle();
        #1;
        check("R5", ptr_x, 16'hCAFE);
        check("R5", ptr_y, 16'h1234);
        check("R5", ptr_z, 16'h8001);

        // R9: read during write returns the old value until the edge
        @(negedge clk) begin wr_en = 1'b1; wr_idx = 5'd5; wr_data = 16'h0001; rd_a_idx = 5'd5; end
        #1;
        check("R9", {8'h00, rd_a_byte}, 16'h00A5);
        @(posedge clk);
        @(negedge clk) idle();
        #1;
        check("R9", {8'h00, rd_a_byte}, 16'h0001);

        // R1: reset after traffic clears every register
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        for (int i = 0; i < 32; i++) begin
            rd_b_idx = 5'(i); #0.1;
            check("R1", {8'h00, rd_b_byte}, 16'h0000);
        end
        check("R1", ptr_z, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule